// File: doc/BRIEF.md
# Prioritised Interrupt Request Controller

This block collects 63 level-sensitive interrupt requests and presents the processor with one winner: a 3-bit interrupt level and the 6-bit number of the source that owns it. Software programs the block through a small read/write register bus. Byte enables let a single write touch one byte or a whole word.

Each source n (1 to 63) has a 6-bit configuration made of a 3-bit level and a 3-bit priority. A 64-bit disable mask sits in two 32-bit words. Bit 0 of the low word is not a source mask; it is a global "silence everything" switch. Sources 1 to 7 have a level fixed to their own number; only their priority can be programmed.

Requests are registered once. Arbitration then picks, among the eligible sources, the one with the highest level, then the highest priority. A remaining tie goes to the higher source number.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset both mask words read 0xFFFFFFFF. Every programmable configuration byte reads 0. The outputs show level 0 and source 0.
- R2: Register addresses are as follows. The high mask word is at 0x00 and the low mask word at 0x04. The configuration byte of source n is at byte address 0x40+n, which is word 0x40+4*(n/4), byte lane n%4 (data bits 8*(n%4)+7 down to 8*(n%4)). Byte enable b selects lane b, and lanes that are not enabled keep their value. Any other address reads 0.
- R3: Mask bit n lives in the high word when n[5]=1 and in the low word when n[5]=0, at bit n[4:0]. A 1 disables source n and a 0 enables it.
- R4: While bit 0 of the low mask word is 1, the output level is 0 and the source is 0, whatever the other bits and requests hold.
- R5: In a configuration byte, bits 5:3 hold the level and bits 2:0 hold the priority. Bits 7:6 are not stored and read as 0.
- R6: For sources 1 to 7, the level field always reads back as the source number and writes to it are ignored. Their priority field is writable and resets to 0.
- R7: The winner is the eligible source with the highest level. Among equal levels, the highest priority wins. If level and priority are both equal, the higher source number wins.
- R8: A source whose level is 0 never wins, even when it is requested and unmasked.
- R9: When no source is eligible, the outputs show level 0 and source 0. Otherwise they show the winner's level and number.
- R10: A change on a request input reaches the outputs on the first rising clock edge after it, and not before. Dropping a request removes it after that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | 63 | Level-sensitive requests; bit n is source n (1..63) |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address of the access |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_level | output | 3 | Level of the winning source, 0 when none |
| irq_src | output | 6 | Number of the winning source, 0 when none |

## Verification
The assertion that pending state mirrors the previous request vector assumes that the requests stay at 0 while reset is held. The bench holds them low until reset has been released. The winner checks assume the configuration changes only through bus writes. The bench therefore never changes a request and writes a register in the same cycle, and it samples the outputs only once a full edge has passed since the last change. Ties in level and priority are created on purpose once, so the source-number ordering is exercised rather than assumed away.

// File: rtl/irqc_pkg.sv
// Shared constants and types for the prioritised interrupt controller.
// Assumes a 7-bit byte address space and 6-bit per-source configuration.
package irqc_pkg;
    localparam int unsigned LVL_W  = 3;
    localparam int unsigned PRI_W  = 3;
    localparam int unsigned KEY_W  = LVL_W + PRI_W;

    localparam logic [6:0] ADR_MASK_HI   = 7'h00;
    localparam logic [6:0] ADR_MASK_LO   = 7'h04;
    localparam logic [6:0] ADR_CTRL_BASE = 7'h40;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [PRI_W-1:0] pri;
    } src_cfg_t;
endpackage

// File: rtl/irqc_regs.sv
// Register file: two mask words and one configuration byte per source.
// Assumes SRC_CNT = 2*DATA_W and the config window occupies the upper half
// of the address space (address MSB set). Source 0 has no storage.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned SRC_CNT   = 64,
    parameter int unsigned FIXED_CNT = 7,
    parameter int unsigned ADDR_W    = 7,
    parameter int unsigned DATA_W    = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W/8-1:0]     bus_be,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic [SRC_CNT-1:0]      mask_vec,
    output src_cfg_t [SRC_CNT-1:0]  cfg_vec
);
    localparam int unsigned LANES  = DATA_W / 8;
    localparam int unsigned LANE_W = $clog2(LANES);
    localparam int unsigned HALF   = SRC_CNT / 2;

    logic [HALF-1:0] mask_hi_q;
    logic [HALF-1:0] mask_lo_q;
    logic            wr_en;

    assign wr_en    = bus_sel & bus_wr;
    assign mask_vec = {mask_hi_q, mask_lo_q};

    // Mask word storage with per-lane write enables; reset masks everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_hi_q <= '1;
            mask_lo_q <= '1;
        end else if (wr_en) begin
            for (int b = 0; b < LANES; b++) begin
                if (bus_be[b] && bus_addr == ADR_MASK_HI)
                    mask_hi_q[8*b +: 8] <= bus_wdata[8*b +: 8];
                if (bus_be[b] && bus_addr == ADR_MASK_LO)
                    mask_lo_q[8*b +: 8] <= bus_wdata[8*b +: 8];
            end
        end
    end

    for (genvar n = 0; n < SRC_CNT; n++) begin : g_src
        localparam logic [ADDR_W-1:0] WADR = ADR_CTRL_BASE + ADDR_W'((n / LANES) * LANES);
        localparam int unsigned       LANE = n % LANES;
        if (n == 0) begin : g_none
            assign cfg_vec[n] = '0;
        end else if (n <= FIXED_CNT) begin : g_fixed
            logic             hit;
            logic [PRI_W-1:0] pri_q;
            assign hit = wr_en & (bus_addr == WADR) & bus_be[LANE];
            // Priority-only storage; the level is tied to the source number.
            always_ff @(posedge clk) begin
                if (!rst_n)   pri_q <= '0;
                else if (hit) pri_q <= bus_wdata[8*LANE +: PRI_W];
            end
            assign cfg_vec[n] = '{lvl: LVL_W'(n), pri: pri_q};
        end else begin : g_prog
            logic     hit;
            src_cfg_t cfg_q;
            assign hit = wr_en & (bus_addr == WADR) & bus_be[LANE];
            // Full level and priority storage for a programmable source.
            always_ff @(posedge clk) begin
                if (!rst_n)   cfg_q <= '0;
                else if (hit) cfg_q <= bus_wdata[8*LANE +: KEY_W];
            end
            assign cfg_vec[n] = cfg_q;
        end
    end

    // Read mux: mask words, or four configuration bytes of an aligned word.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADR_MASK_HI) begin
            bus_rdata = mask_hi_q;
        end else if (bus_addr == ADR_MASK_LO) begin
            bus_rdata = mask_lo_q;
        end else if (bus_addr[ADDR_W-1] && bus_addr[LANE_W-1:0] == '0) begin
            for (int b = 0; b < LANES; b++) begin
                bus_rdata[8*b +: 8] =
                    {2'b00, cfg_vec[{bus_addr[ADDR_W-2:LANE_W], LANE_W'(b)}]};
            end
        end
    end
endmodule

// File: rtl/irqc_arb.sv
// Arbiter: finds the eligible source with the largest {level, priority}
// key; ties go to the higher source number. Assumes pend_vec is registered.
module irqc_arb
    import irqc_pkg::*;
#(
    parameter int unsigned SRC_CNT = 64,
    parameter int unsigned SRC_W   = $clog2(SRC_CNT)
) (
    input  logic [SRC_CNT-1:0]      pend_vec,
    input  logic [SRC_CNT-1:0]      mask_vec,
    input  src_cfg_t [SRC_CNT-1:0]  cfg_vec,
    output logic [LVL_W-1:0]        irq_level,
    output logic [SRC_W-1:0]        irq_src
);
    logic [KEY_W-1:0] best_key;
    logic [SRC_W-1:0] best_src;

    // Ascending scan with >= so that the last (highest) source wins a tie.
    always_comb begin
        best_key = '0;
        best_src = '0;
        for (int n = 0; n < SRC_CNT; n++) begin
            if (pend_vec[n] && !mask_vec[n] && !mask_vec[0] &&
                cfg_vec[n].lvl != '0 && cfg_vec[n] >= best_key) begin
                best_key = cfg_vec[n];
                best_src = SRC_W'(n);
            end
        end
    end

    assign irq_level = best_key[KEY_W-1 -: LVL_W];
    assign irq_src   = best_src;
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top of the prioritised interrupt controller: registers the requests,
// holds the configuration, and arbitrates combinationally to the outputs.
// Assumes level-sensitive requests, synchronous to clk.
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned SRC_CNT   = 64,
    parameter int unsigned FIXED_CNT = 7,
    parameter int unsigned ADDR_W    = 7,
    parameter int unsigned DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_CNT-1:1]   irq_req,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W/8-1:0]  bus_be,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [LVL_W-1:0]     irq_level,
    output logic [$clog2(SRC_CNT)-1:0] irq_src
);
    localparam int unsigned SRC_W = $clog2(SRC_CNT);

    logic [SRC_CNT-1:0]     pend_q;
    logic [SRC_CNT-1:0]     mask_vec;
    src_cfg_t [SRC_CNT-1:0] cfg_vec;

    // Single register stage on the requests; slot 0 is never pending.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= {irq_req, 1'b0};
    end

    irqc_regs #(
        .SRC_CNT(SRC_CNT), .FIXED_CNT(FIXED_CNT),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mask_vec(mask_vec), .cfg_vec(cfg_vec)
    );

    irqc_arb #(.SRC_CNT(SRC_CNT), .SRC_W(SRC_W)) u_arb (
        .pend_vec(pend_q), .mask_vec(mask_vec), .cfg_vec(cfg_vec),
        .irq_level(irq_level), .irq_src(irq_src)
    );
endmodule

// File: rtl/irqc_chk.sv
// Checker for prio_irq_ctrl: relates the outputs to the registered
// pending, mask and configuration state. Assumes requests are 0 in reset.
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int unsigned SRC_CNT = 64
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [SRC_CNT-1:1]      irq_req,
    input logic [SRC_CNT-1:0]      pend_vec,
    input logic [SRC_CNT-1:0]      mask_vec,
    input src_cfg_t [SRC_CNT-1:0]  cfg_vec,
    input logic [LVL_W-1:0]        irq_level,
    input logic [$clog2(SRC_CNT)-1:0] irq_src
);
    AST_MASKALL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        mask_vec[0] |-> irq_level == '0); // R4
    AST_IDLE_SRC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level == '0 |-> irq_src == '0); // R9
    AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level != '0 |-> pend_vec[irq_src] && !mask_vec[irq_src]); // R3
    AST_LEVEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level != '0 |-> cfg_vec[irq_src].lvl == irq_level); // R5
    AST_PEND_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> pend_vec[SRC_CNT-1:1] == $past(irq_req)); // R10
endmodule

bind prio_irq_ctrl irqc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .pend_vec(pend_q), .mask_vec(mask_vec), .cfg_vec(cfg_vec),
    .irq_level(irq_level), .irq_src(irq_src)
);

// File: tb/tb_prio_irq_ctrl.sv
// Directed bench for prio_irq_ctrl; each task checks its own scenario.
module tb_prio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] req_v = '0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq_level;
    logic [5:0]  irq_src;
    int          vectors = 0, miscompares = 0;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    prio_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_req(req_v[63:1]),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_level(irq_level), .irq_src(irq_src)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_out(input string tag, input logic [2:0] lvl, input logic [5:0] src);
        check({tag, " level"}, 32'(irq_level), 32'(lvl));
        check({tag, " source"}, 32'(irq_src), 32'(src));
    endtask

    task automatic bus_write(input logic [6:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic bus_read(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic set_req(input logic [63:0] v);
        @(negedge clk);
        req_v = v;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check_out("R1 reset outputs", 3'd0, 6'd0);
        bus_read(7'h00, d); check("R1 mask high", d, 32'hFFFF_FFFF);
        bus_read(7'h04, d); check("R1 mask low", d, 32'hFFFF_FFFF);
        bus_read(7'h48, d); check("R1 config sources 8..11", d, 32'h0);
        bus_read(7'h40, d); check("R6 fixed levels sources 0..3", d, 32'h1810_0800);
        bus_read(7'h20, d); check("R2 unmapped reads zero", d, 32'h0);
    endtask

    task automatic t_maskall_and_first();
        logic [31:0] d;
        bus_write(7'h48, 32'h002A_0000, 4'b0100);
        bus_read(7'h48, d); check("R2 lane 2 write", d, 32'h002A_0000);
        bus_write(7'h04, 32'hFFFF_FBFF, 4'hF);
        set_req(64'h1 << 10);
        check_out("R4 mask-all blocks", 3'd0, 6'd0);
        bus_write(7'h04, 32'hFFFF_FBFE, 4'hF);
        check_out("R3 source 10 enabled", 3'd5, 6'd10);
    endtask

    task automatic t_latency();
        @(negedge clk);
        req_v = '0;
        #1 check_out("R10 before edge", 3'd5, 6'd10);
        @(posedge clk); #1;
        check_out("R10 drop after edge", 3'd0, 6'd0);
        set_req(64'h1 << 10);
        check_out("R10 raise after edge", 3'd5, 6'd10);
    endtask

    task automatic t_level_zero();
        bus_write(7'h00, 32'hFFFF_FEFF, 4'hF);
        set_req((64'h1 << 10) | (64'h1 << 40));
        check_out("R8 level-0 source ignored", 3'd5, 6'd10);
    endtask

    task automatic t_order();
        logic [31:0] d;
        bus_write(7'h68, 32'h0000_0031, 4'b0001);
        check_out("R7 higher level wins", 3'd6, 6'd40);
        bus_write(7'h54, 32'h0000_0034, 4'b0001);
        bus_write(7'h04, 32'hFFEF_FBFE, 4'hF);
        set_req((64'h1 << 10) | (64'h1 << 20) | (64'h1 << 40));
        check_out("R7 higher priority wins", 3'd6, 6'd20);
        bus_write(7'h68, 32'h0000_3400, 4'b0010);
        bus_read(7'h68, d); check("R2 neighbour lane kept", d, 32'h0000_3431);
        bus_write(7'h00, 32'hFFFF_FCFF, 4'hF);
        set_req((64'h1 << 10) | (64'h1 << 20) | (64'h1 << 40) | (64'h1 << 41));
        check_out("R7 tie to higher number", 3'd6, 6'd41);
        bus_write(7'h00, 32'hFFFF_FEFF, 4'hF);
        bus_write(7'h04, 32'hFFFF_FBFE, 4'hF);
        check_out("R3 masked sources skipped", 3'd6, 6'd40);
    endtask

    task automatic t_fixed();
        logic [31:0] d;
        bus_write(7'h44, 32'hFF00_0000, 4'b1000);
        bus_read(7'h44, d); check("R6 level kept priority written", d, 32'h3F30_2820);
        bus_write(7'h04, 32'hFFFF_FB7E, 4'hF);
        set_req((64'h1 << 7) | (64'h1 << 10) | (64'h1 << 40) | (64'h1 << 41));
        check_out("R6 fixed source level 7 wins", 3'd7, 6'd7);
        bus_write(7'h48, 32'h00C5_0000, 4'b0100);
        bus_read(7'h48, d); check("R5 upper bits dropped", d, 32'h0005_0000);
    endtask

    task automatic t_maskall_again();
        logic [31:0] d;
        bus_write(7'h04, 32'h0000_0001, 4'hF);
        check_out("R4 write of 1 silences", 3'd0, 6'd0);
        bus_read(7'h04, d); check("R3 low word readback", d, 32'h0000_0001);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_maskall_and_first();
        t_latency();
        t_level_zero();
        t_order();
        t_fixed();
        t_maskall_again();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule